// File: doc/BRIEF.md
# Microcode ALU with Carry Flag

This block is the execute stage of a 16-bit microcode engine. Each cycle it receives two operands, an operation code and two small immediate fields, and returns a 16-bit result combinationally. Arithmetic, bitwise, shift and rotate operations are available. There are also two operations that treat the operands as a register pair: one extracts a bit field from the pair, and the other merges a rotated slice of one operand into the other.

The block holds a single carry flag register. Add and subtract each come in a plain form and a form that uses the stored carry as an input. Every one of these four forms has a flag-writing variant and a variant that leaves the flag alone. The flag changes only at a clock edge where `en_i` is high and the operation is a flag-writing variant. A register copy is not a separate operation: it is issued as OR with a zero second operand.

Top module: `uc_alu`

## Requirements
- R1: While `rst_n` is low, and immediately after it rises, `carry_o` is 0.
- R2: Add codes 0 and 1 give (A+B) mod 2^16. Add-with-carry codes 2 and 3 give (A+B+C) mod 2^16, where C is the stored flag.
- R3: Subtract codes 4 and 5 give (A−B) mod 2^16. Subtract-with-carry codes 6 and 7 give (A−B−(1−C)) mod 2^16. In both cases the carry means "no borrow".
- R4: When `en_i` is high and the code is 1, 3, 5 or 7, the flag takes a new value at the clock edge. For an add it becomes the carry out of bit 15. For a subtract it becomes 1 exactly when the true difference is not negative.
- R5: The flag keeps its value at every edge where `en_i` is low or the code is any other value.
- R6: Code 8 gives A|B, code 9 gives A&B, code 10 gives A^B and code 11 gives A&~B. Code 8 with B=0 returns A unchanged.
- R7: Code 12 shifts A left and code 13 shifts A right, in both cases by B[3:0] with zero fill.
- R8: Code 14 shifts A right by B[3:0] and fills the vacated bits with copies of A[15].
- R9: Code 15 rotates A left and code 16 rotates A right, in both cases by B[3:0].
- R10: Code 17 forms the 32-bit pair {B,A} and shifts it right by `sh_i`. The result keeps the low `len_i`+1 bits and clears the rest.
- R11: Code 18 builds a mask of `len_i`+1 ones starting at bit `sh_i`, cut off at bit 15. Where the mask is set, the result bit comes from A rotated left by `sh_i`. Everywhere else the result bit comes from B.
- R12: Codes 19 to 31 give a result of 0 and do not change the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flag |
| en_i | input | 1 | Operation issue strobe; qualifies flag writes |
| op_i | input | 5 | Operation code |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B (also the shift amount source) |
| sh_i | input | 4 | Immediate shift for the pair operations |
| len_i | input | 4 | Immediate field length minus one |
| res_o | output | 16 | Result |
| carry_o | output | 1 | Stored carry flag |

## Verification
The hardest case to reach from the ports is a carry-using operation with a known, varied carry-in. The flag can only be set by an earlier flag-writing operation, so its value depends on the history of operations. The stimulus therefore runs a long random stream in which flag-writing adds and subtracts are mixed with carry-consuming operations and with cycles where `en_i` is low. The bench follows the flag in its own model. Directed sweeps then cover every shift amount and every (`sh_i`, `len_i`) pair, which includes the merge masks that run past bit 15.

// File: rtl/uc_alu_pkg.sv
package uc_alu_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_ADDF = 5'd1,  OP_ADC  = 5'd2,  OP_ADCF = 5'd3,
    OP_SUB  = 5'd4,  OP_SUBF = 5'd5,  OP_SBC  = 5'd6,  OP_SBCF = 5'd7,
    OP_OR   = 5'd8,  OP_AND  = 5'd9,  OP_XOR  = 5'd10, OP_CLR  = 5'd11,
    OP_SHL  = 5'd12, OP_SHR  = 5'd13, OP_SAR  = 5'd14, OP_ROL  = 5'd15,
    OP_ROR  = 5'd16, OP_XSHR = 5'd17, OP_MRG  = 5'd18
  } alu_op_e;

  typedef enum logic [1:0] {U_ARITH, U_LOGIC, U_SHIFT, U_NONE} unit_e;

  function automatic unit_e unit_of(logic [OPW-1:0] op);
    if (op <= OP_SBCF)      return U_ARITH;
    else if (op <= OP_CLR)  return U_LOGIC;
    else if (op <= OP_MRG)  return U_SHIFT;
    else                    return U_NONE;
  endfunction

  function automatic logic writes_flag(logic [OPW-1:0] op);
    return (op <= OP_SBCF) && op[0];
  endfunction
endpackage

// File: rtl/uc_alu_arith.sv
module uc_alu_arith
  import uc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   sum,
  output logic           cout
);
  function automatic logic [W:0] add_core(logic [W-1:0] x, logic [W-1:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  logic           is_sub;
  logic           use_c;
  logic [W-1:0]   b_eff;
  logic           c_eff;
  logic [W:0]     full;

  always_comb begin
    is_sub = op[2];
    use_c  = op[1];
    b_eff  = is_sub ? ~b : b;
    c_eff  = use_c ? cin : is_sub;
    full   = add_core(a, b_eff, c_eff);
    sum    = full[W-1:0];
    cout   = full[W];
  end

  // Equal operands on plain subtract: zero result, no borrow (R3)
  p_sub_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_SUB || op == OP_SUBF) && a == b) |-> (sum == '0 && cout));

  // Adding zero without carry-in never produces a carry (R2)
  p_add_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_ADD || op == OP_ADDF) && b == '0) |-> (sum == a && !cout));
endmodule

// File: rtl/uc_alu_logic.sv
module uc_alu_logic
  import uc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res
);
  always_comb begin
    unique case (op)
      OP_OR:   res = a | b;
      OP_AND:  res = a & b;
      OP_XOR:  res = a ^ b;
      OP_CLR:  res = a & ~b;
      default: res = '0;
    endcase
  end

  // Bit clear never leaves a bit set where B is set (R6)
  p_clr_disjoint_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLR) |-> ((res & b) == '0));

  // OR keeps every bit of A (R6)
  p_or_covers_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_OR) |-> ((res & a) == a));
endmodule

// File: rtl/uc_alu_shift.sv
module uc_alu_shift
  import uc_alu_pkg::*;
#(
  parameter int W = 16,
  localparam int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [SHW-1:0] imm_sh,
  input  logic [SHW-1:0] imm_len,
  output logic [W-1:0]   res
);
  function automatic logic [W-1:0] rotl(logic [W-1:0] x, logic [SHW-1:0] n);
    logic [2*W-1:0] dbl;
    dbl = {x, x} << n;
    return dbl[2*W-1:W];
  endfunction

  function automatic logic [W-1:0] rotr(logic [W-1:0] x, logic [SHW-1:0] n);
    logic [2*W-1:0] dbl;
    dbl = {x, x} >> n;
    return dbl[W-1:0];
  endfunction

  function automatic logic [W-1:0] low_ones(logic [SHW-1:0] len);
    return {W{1'b1}} >> (SHW'(W - 1) - len);
  endfunction

  logic [SHW-1:0]  amt;
  logic [2*W-1:0]  pair_sh;
  logic [W-1:0]    fld_mask;
  logic [W-1:0]    mrg_mask;

  assign amt      = b[SHW-1:0];
  assign pair_sh  = {b, a} >> imm_sh;
  assign fld_mask = low_ones(imm_len);
  assign mrg_mask = fld_mask << imm_sh;

  always_comb begin
    unique case (op)
      OP_SHL:  res = a << amt;
      OP_SHR:  res = a >> amt;
      OP_SAR:  res = W'($signed(a) >>> amt);
      OP_ROL:  res = rotl(a, amt);
      OP_ROR:  res = rotr(a, amt);
      OP_XSHR: res = pair_sh[W-1:0] & fld_mask;
      OP_MRG:  res = (rotl(a, imm_sh) & mrg_mask) | (b & ~mrg_mask);
      default: res = '0;
    endcase
  end

  // Rotates preserve the population count (R9)
  p_rot_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ROL || op == OP_ROR) |-> ($countones(res) == $countones(a)));

  // Arithmetic shift keeps the sign bit (R8)
  p_sar_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SAR) |-> (res[W-1] == a[W-1]));

  // Extracted field has nothing above bit len (R10)
  p_xshr_field_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XSHR) |-> (((res >> imm_len) >> 1) == '0));

  // Merge leaves B intact below the shift point (R11)
  p_mrg_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MRG) |-> (((res ^ b) & ~({W{1'b1}} << imm_sh)) == '0));
endmodule

// File: rtl/uc_alu.sv
module uc_alu
  import uc_alu_pkg::*;
#(
  parameter int W = 16,
  localparam int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic [4:0]     op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [SHW-1:0] sh_i,
  input  logic [SHW-1:0] len_i,
  output logic [W-1:0]   res_o,
  output logic           carry_o
);
  logic [W-1:0] arith_res;
  logic         arith_cout;
  logic [W-1:0] logic_res;
  logic [W-1:0] shift_res;
  logic         carry_q;
  logic         flag_wr;
  unit_e        unit_sel;

  uc_alu_arith #(.W(W)) u_arith (
    .clk(clk), .rst_n(rst_n), .op(op_i), .a(a_i), .b(b_i),
    .cin(carry_q), .sum(arith_res), .cout(arith_cout)
  );

  uc_alu_logic #(.W(W)) u_logic (
    .clk(clk), .rst_n(rst_n), .op(op_i), .a(a_i), .b(b_i), .res(logic_res)
  );

  uc_alu_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .op(op_i), .a(a_i), .b(b_i),
    .imm_sh(sh_i), .imm_len(len_i), .res(shift_res)
  );

  assign unit_sel = unit_of(op_i);
  assign flag_wr  = en_i && writes_flag(op_i);

  always_comb begin
    unique case (unit_sel)
      U_ARITH: res_o = arith_res;
      U_LOGIC: res_o = logic_res;
      U_SHIFT: res_o = shift_res;
      default: res_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       carry_q <= 1'b0;
    else if (flag_wr) carry_q <= arith_cout;
  end

  assign carry_o = carry_q;

  // Flag-writing issue loads the adder carry out (R4)
  p_carry_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && op_i <= 5'd7 && op_i[0]) |=> (carry_o == $past(arith_cout)));

  // Any other cycle leaves the flag alone (R5)
  p_carry_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_i && op_i <= 5'd7 && op_i[0]) |=> $stable(carry_o));

  // Unassigned codes yield zero (R12)
  p_undef_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > 5'd18) |-> (res_o == '0));
endmodule

// File: tb/uc_alu_test.sv
module uc_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic [3:0]  sh_i = '0;
  logic [3:0]  len_i = '0;
  logic [15:0] res_o;
  logic        carry_o;

  int n_chk = 0;
  int n_fail = 0;
  logic mc = 1'b0;   // model carry
  bit done = 0;

  always #2.5 clk = ~clk;

  uc_alu uut (.*);

  function automatic string req_of(logic [4:0] op);
    if (op <= 1 || op == 2 || op == 3) return "R2";
    if (op <= 7)  return "R3";
    if (op <= 11) return "R6";
    if (op <= 13) return "R7";
    if (op == 14) return "R8";
    if (op <= 16) return "R9";
    if (op == 17) return "R10";
    if (op == 18) return "R11";
    return "R12";
  endfunction

  // Independent model: returns result, carry out of the arithmetic
  task automatic model(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [3:0] sh, input logic [3:0] len, input logic c,
                       output logic [15:0] r, output logic co);
    int s;
    int n;
    logic [31:0] pair;
    logic cu;
    r = '0; co = 1'b0;
    n = int'(b[3:0]);
    cu = (op == 2 || op == 3 || op == 6 || op == 7) ? c : 1'b1;
    pair = {b, a};
    if (op <= 3) begin
      s = int'(a) + int'(b) + ((op >= 2) ? int'(c) : 0);
      r = 16'(s); co = (s > 65535);
    end else if (op <= 7) begin
      s = int'(a) - int'(b) - (cu ? 0 : 1);
      r = 16'(s); co = (s >= 0);
    end else case (op)
      8:  r = a | b;
      9:  r = a & b;
      10: r = a ^ b;
      11: r = a & ~b;
      12: r = a << n;
      13: r = a >> n;
      14: r = 16'($signed(a) >>> n);
      15: for (int i = 0; i < 16; i++) r[(i + n) % 16] = a[i];
      16: for (int i = 0; i < 16; i++) r[i] = a[(i + n) % 16];
      17: for (int i = 0; i < 16; i++)
            r[i] = (i <= int'(len)) ? pair[i + int'(sh)] : 1'b0;
      18: for (int i = 0; i < 16; i++)
            r[i] = (i >= int'(sh) && i - int'(sh) <= int'(len)) ?
                   a[(i - int'(sh) + 16) % 16] : b[i];
      default: r = '0;
    endcase
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue one operation: check result mid-cycle, then the flag after the edge
  task automatic issue(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [3:0] sh, input logic [3:0] len, input logic en);
    logic [15:0] er;
    logic ec;
    logic wr;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; sh_i = sh; len_i = len; en_i = en;
    model(op, a, b, sh, len, mc, er, ec);
    #1;
    chk(req_of(op), res_o, er);
    wr = en && op <= 7 && op[0];
    if (wr) mc = ec;
    @(posedge clk);
    #1;
    chk(wr ? "R4" : "R5", {15'd0, carry_o}, {15'd0, mc});
  endtask

  function automatic logic [15:0] pick(input int sel);
    case (sel % 8)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h7FFF;
      4: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    // R1: reset state
    #7;
    chk("R1", {15'd0, carry_o}, 16'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", {15'd0, carry_o}, 16'd0);

    // Directed: carry produced, then consumed (R2, R4)
    issue(5'd1, 16'hFFFF, 16'h0001, 4'd0, 4'd0, 1'b1);
    issue(5'd2, 16'h0010, 16'h0020, 4'd0, 4'd0, 1'b1);
    // R5: en low with a flag-writing code
    issue(5'd5, 16'h0000, 16'h0001, 4'd0, 4'd0, 1'b0);
    // R3: borrow case via flag-writing subtract, then subtract with borrow-in
    issue(5'd5, 16'h0000, 16'h0001, 4'd0, 4'd0, 1'b1);
    issue(5'd6, 16'h0005, 16'h0003, 4'd0, 4'd0, 1'b1);
    // R6: copy through OR with zero
    issue(5'd8, 16'hA5C3, 16'h0000, 4'd0, 4'd0, 1'b1);

    // R7, R8, R9: every shift amount on a sign-set pattern
    for (int op = 12; op <= 16; op++)
      for (int n = 0; n < 16; n++)
        issue(5'(op), 16'hB3C1, 16'(n) | 16'hF0A0, 4'd0, 4'd0, 1'b1);

    // R10, R11: every immediate pair
    for (int op = 17; op <= 18; op++)
      for (int s = 0; s < 16; s++)
        for (int l = 0; l < 16; l++)
          issue(5'(op), 16'h9C35, 16'h6E1B, 4'(s), 4'(l), 1'b1);

    // Mixed random stream; carry history drives carry-using codes (R2-R12)
    for (int k = 0; k < 4000; k++)
      issue(5'($urandom_range(0, 31)), pick($urandom), pick($urandom),
            4'($urandom), 4'($urandom), ($urandom_range(0, 7) != 0));

    // R1: reset while the flag is set
    issue(5'd1, 16'h8000, 16'h8000, 4'd0, 4'd0, 1'b1);
    @(negedge clk); rst_n = 1'b0; mc = 1'b0;
    #1;
    chk("R1", {15'd0, carry_o}, 16'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule